// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a four-bank, 32-bit SDRAM from reset until the memory can take normal traffic. While a start-up window is timed, it drives nothing but NOP. It then walks a fixed script: one precharge of every bank, two auto-refresh commands, and one load of the mode register. Each command is followed by its own wait, counted in clock cycles, before the next one goes out. When the wait after the mode load has run out, it raises a done flag that stays high. At that point a controller that follows can take over the bus.

All timing is set by parameters in clock cycles. These are the start-up window, the precharge-to-command gap, the refresh-to-command gap and the mode-load-to-command gap. The 11-bit mode value comes in on an input port. It is sampled on the clock edge that issues the mode load. The command, bank and address outputs are all registered, so the bus changes only on clock edges and has no glitches. No data moves through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, and for the first `STARTUP_CYC` cycles after it is released, the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111) and `done` is low.
- R2: In cycle `STARTUP_CYC`+1 after release (cycle 1 is the one after the first rising edge with `rst_n` high), the bus carries PRECHARGE (4'b0010) for one cycle, with `addr`[10] = 1, `addr`[9:0] = 0 and `ba` = 0.
- R3: AUTO REFRESH (4'b0001), with `addr` and `ba` at zero, appears exactly twice. The first is `TRP_CYC` cycles after the precharge and the second is `TRC_CYC` cycles after the first.
- R4: LOAD MODE (4'b0000) appears once, `TRC_CYC` cycles after the second refresh. It carries `ba` = 0, and `addr` equals the `mode_word` present at the clock edge that issued it.
- R5: `done` rises `TMRD_CYC` cycles after the mode load and stays high until reset. It is never high earlier.
- R6: Every cycle that is not one of the four command cycles carries NOP with `addr` and `ba` at zero. This includes every cycle after `done`.
- R7: Pulling `rst_n` low at any point forces NOP and `done` low at once. Releasing it restarts the whole script from the start-up window.
- R8: `mode_word` has no effect on the bus in any cycle other than the mode-load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 11 | Value written into the SDRAM mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | 11 | Address bus; A10 selects all banks on precharge |
| done | output | 1 | High once the initialization script has finished |

## Verification
A step register that is off by one, or a gap counter that is loaded wrongly, moves a command to the wrong cycle. It can also repeat a command or skip one. Because the bench compares every bus cycle against arithmetically placed command slots, such a fault shows up in the first cycle where the slot moves. That is never later than the command that follows the faulty step. A mode value latched at the wrong edge, or bus lines that are not cleared, shows at once on `addr` during the mode-load or gap cycles. Two parameter sets are used, the second with one-cycle gaps, so that every command is adjacent to the next.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encodings on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  // Script steps in issue order; the order is the behaviour
  typedef enum logic [2:0] {
    STP_WAIT = 3'd0,
    STP_PRE  = 3'd1,
    STP_REF1 = 3'd2,
    STP_REF2 = 3'd3,
    STP_LMR  = 3'd4,
    STP_RDY  = 3'd5
  } step_e;

  // Command driven in the first cycle of a step
  function automatic cmd_e step_cmd(step_e s);
    case (s)
      STP_PRE:  return CMD_PRE;
      STP_REF1: return CMD_REF;
      STP_REF2: return CMD_REF;
      STP_LMR:  return CMD_LMR;
      default:  return CMD_NOP;
    endcase
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CW      = 4,
  parameter int unsigned RST_VAL = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  localparam logic [CW-1:0] RST_CNT = CW'(RST_VAL);

  logic [CW-1:0] cnt_q;

  // Down-counter: reload on request, otherwise count to zero and park
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= RST_CNT;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3
  tmr_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

  // R1
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned TRC_CYC  = 9,
  parameter int unsigned TMRD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_zero,
  output step_e         step_q,
  output step_e         step_nxt,
  output logic          adv,
  output logic [CW-1:0] load_val
);

  // A step lasting N cycles reloads the timer with N-1
  localparam logic [CW-1:0] LV_RP  = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] LV_RC  = CW'(TRC_CYC - 1);
  localparam logic [CW-1:0] LV_MRD = CW'(TMRD_CYC - 1);

  assign adv = tmr_zero && (step_q != STP_RDY);

  always_comb begin
    step_nxt = step_q;
    if (adv) step_nxt = step_e'(step_q + 3'd1);
  end

  always_comb begin
    case (step_nxt)
      STP_PRE:  load_val = LV_RP;
      STP_REF1: load_val = LV_RC;
      STP_REF2: load_val = LV_RC;
      STP_LMR:  load_val = LV_MRD;
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= STP_WAIT;
    else        step_q <= step_nxt;
  end

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_q) |-> (step_q == step_e'($past(step_q) + 3'd1)));

  // R5
  step_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STP_RDY) |=> (step_q == STP_RDY));

  // R3
  step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_q) |-> $past(tmr_zero));

endmodule

// File: rtl/sdram_init_cmdreg.sv
module sdram_init_cmdreg
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  step_e             step_nxt,
  input  logic [ADDR_W-1:0] mode_word,
  output cmd_e              cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  cmd_e              cmd_d;
  logic [ADDR_W-1:0] addr_d;

  // A command goes out only on the edge that enters a step
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    if (adv) begin
      cmd_d = step_cmd(step_nxt);
      if (step_nxt == STP_PRE) addr_d[AP_BIT] = 1'b1;
      if (step_nxt == STP_LMR) addr_d = mode_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= '0;
      addr_q <= addr_d;
      done_q <= done_q | (adv && (step_nxt == STP_RDY));
    end
  end

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (addr_q[AP_BIT] && ba_q == '0));

  // R4
  lmr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_LMR) |-> (ba_q == '0 && addr_q == $past(mode_word)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == CMD_NOP && addr_q == '0));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 10000,
  parameter int unsigned TRP_CYC     = 3,
  parameter int unsigned TRC_CYC     = 9,
  parameter int unsigned TMRD_CYC    = 2,
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BANK_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int unsigned MAXV = max_of4(STARTUP_CYC, TRP_CYC, TRC_CYC, TMRD_CYC);
  localparam int unsigned CW   = (MAXV < 2) ? 1 : $clog2(MAXV + 1);

  logic          tmr_zero;
  logic          adv;
  logic [CW-1:0] load_val;
  step_e         step_q;
  step_e         step_nxt;
  cmd_e          cmd_q;

  sdram_init_timer #(
    .CW      (CW),
    .RST_VAL (STARTUP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (adv),
    .load_val (load_val),
    .zero     (tmr_zero)
  );

  sdram_init_fsm #(
    .CW       (CW),
    .TRP_CYC  (TRP_CYC),
    .TRC_CYC  (TRC_CYC),
    .TMRD_CYC (TMRD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_zero (tmr_zero),
    .step_q   (step_q),
    .step_nxt (step_nxt),
    .adv      (adv),
    .load_val (load_val)
  );

  sdram_init_cmdreg #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .step_nxt  (step_nxt),
    .mode_word (mode_word),
    .cmd_q     (cmd_q),
    .ba_q      (ba),
    .addr_q    (addr),
    .done_q    (done)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  // R1
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STP_WAIT) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !done));

  // R5
  done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step_q == STP_RDY));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;

  localparam int unsigned A_S = 12, A_RP = 3, A_RC = 4, A_MRD = 2;
  localparam int unsigned B_S = 1,  B_RP = 1, B_RC = 1, B_MRD = 1;
  localparam int unsigned RUN_LEN = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] mode_word = '0;

  logic       a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba;
  logic [10:0] a_addr;
  logic       b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba;
  logic [10:0] b_addr;

  int checks = 0;
  int failures = 0;
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.STARTUP_CYC(A_S), .TRP_CYC(A_RP), .TRC_CYC(A_RC), .TMRD_CYC(A_MRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
    .ba(a_ba), .addr(a_addr), .done(a_done));

  sdram_init_seq #(.STARTUP_CYC(B_S), .TRP_CYC(B_RP), .TRC_CYC(B_RC), .TMRD_CYC(B_MRD)) dut_min_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
    .ba(b_ba), .addr(b_addr), .done(b_done));

  // Watchdog: expiry counts as a failure and still prints the summary
  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<=100000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Expected bus word {cmd[3:0], ba[1:0], addr[10:0], done} for cycle n
  function automatic logic [17:0] expect_bus(int n, int unsigned s, int unsigned rp,
                                             int unsigned rc, int unsigned md,
                                             logic [10:0] mw);
    int pre, r1, r2, lm, dn;
    pre = int'(s) + 1;
    r1  = pre + int'(rp);
    r2  = r1 + int'(rc);
    lm  = r2 + int'(rc);
    dn  = lm + int'(md);
    if (n == pre)                return {4'b0010, 2'b00, 11'h400, 1'b0};
    if (n == r1 || n == r2)      return {4'b0001, 2'b00, 11'h000, 1'b0};
    if (n == lm)                 return {4'b0000, 2'b00, mw, 1'b0};
    return {4'b0111, 2'b00, 11'h000, (n >= dn && n > 0)};
  endfunction

  function automatic string tag_of(int n, int unsigned s, int unsigned rp,
                                   int unsigned rc, int unsigned md);
    int pre, r1, r2, lm, dn;
    pre = int'(s) + 1;
    r1  = pre + int'(rp);
    r2  = r1 + int'(rc);
    lm  = r2 + int'(rc);
    dn  = lm + int'(md);
    if (n <= int'(s))            return "R1";
    if (n == pre)                return "R2";
    if (n == r1 || n == r2)      return "R3";
    if (n == lm)                 return "R4";
    if (n >= dn)                 return "R5/R6";
    return "R6/R8";
  endfunction

  task automatic check_bus(string name, string tag, logic [17:0] act, logic [17:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: {cmd,ba,addr,done} act=%b_%b_%h_%b exp=%b_%b_%h_%b",
               name, tag, act[17:14], act[13:12], act[11:1], act[0],
               exp[17:14], exp[13:12], exp[11:1], exp[0]);
    end
  endtask

  function automatic logic [10:0] pattern(int run, int n);
    if (run == 0) return 11'h000;
    if (run == 1) return 11'h7FF;
    return 11'((n * 37 + run * 113) ^ (n << 3) ^ (run << 7));
  endfunction

  // Check both devices for cycle n; mode_word is the value seen at edge n
  task automatic check_cycle(int n);
    check_bus("dut_i", tag_of(n, A_S, A_RP, A_RC, A_MRD),
              {a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
              expect_bus(n, A_S, A_RP, A_RC, A_MRD, mode_word));
    check_bus("dut_min_i", tag_of(n, B_S, B_RP, B_RC, B_MRD),
              {b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
              expect_bus(n, B_S, B_RP, B_RC, B_MRD, mode_word));
  endtask

  initial begin
    for (int run = 0; run < 6; run++) begin
      rst_n = 1'b0;
      mode_word = pattern(run, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check_cycle(0);
      rst_n = 1'b1;
      for (int n = 1; n <= RUN_LEN; n++) begin
        @(negedge clk);
        check_cycle(n);
        // R8: vary mode_word each cycle in sweep runs
        mode_word = pattern(run, n);
        if (run == 3 && n == 18) begin
          // R7: abort mid-script; dut_min_i is already done here
          rst_n = 1'b0;
          #1;
          check_bus("dut_i", "R7", {a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done},
                    {4'b0111, 2'b00, 11'h000, 1'b0});
          check_bus("dut_min_i", "R7", {b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done},
                    {4'b0111, 2'b00, 11'h000, 1'b0});
          break;
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule